// File: doc/BRIEF.md
# Hardwired Opcode Control Decoder

This block turns one fixed-length 32-bit instruction word into the control signals a simple datapath needs in the same cycle. It is purely combinational: it picks where the ALU's second operand comes from, which next-PC source the fetch stage uses, and which ALU operation class applies. It also emits a micro-operation code, one merged destination-register index, a second-source register index and an extended immediate.

Two source-level instructions are folded onto existing operations. MOV becomes ADD with the zero register as its second source. INC becomes ADDI with an immediate of one. Opcodes outside the defined set raise an illegal-instruction flag. So does any defined opcode whose bit is set in a run-time disable mask, which lets a faulty function be trapped instead of dispatched. While the flag is raised, every datapath-enabling control stays quiet.

Top module: `op_decoder`

## Requirements
- R1: The opcode is instr[31:27]. The defined encodings are ADD=0, SUB=1, OR=2, MOV=3, ADDI=4, ORI=5, INC=6, LW=7, SW=8, BEQ=9, J=10 and FMA=11. Any other value sets illegal_o=1 and forces reg_we_o, mem_rd_o and mem_wr_o to 0, pc_sel_o to 00, alu_src_imm_o to 0, alu_op_o to 00, uop_o to 0 (NOP), and rd_idx_o, rs2_idx_o and imm_o to 0.
- R2: When op_disable_i[opcode] is 1 for a defined opcode, the outputs are identical to those of an undefined opcode. Mask bits belonging to other opcodes have no effect.
- R3: alu_src_imm_o is 1 (immediate) for ADDI, ORI, INC, LW and SW. It is 0 (register) for every other opcode.
- R4: pc_sel_o is 01 (branch target) for BEQ and 10 (jump target) for J. It is 00 (PC+4) for every other opcode, ADDI included.
- R5: alu_op_o[1] is 1 exactly for the register-form instructions (ADD, SUB, OR, MOV, FMA) and for ORI. alu_op_o[0] is 1 exactly for ORI and BEQ. The resulting codes are 00 add, 01 subtract, 10 register form and 11 or.
- R6: rd_idx_o is instr[26:22] for register-form instructions. It is instr[21:17] for ADDI, ORI, INC and LW. It is 0 whenever reg_we_o is 0.
- R7: MOV gives uop_o equal to ADD's code (1), rs2_idx_o=0, and the same alu_src_imm_o, alu_op_o, pc_sel_o and reg_we_o as ADD.
- R8: INC gives uop_o equal to ADDI's code (4) and imm_o=1, whatever its low 17 bits hold.
- R9: For ADDI, ORI, LW, SW and BEQ, imm_o is instr[16:0] sign-extended to 32 bits. For the other non-INC opcodes it is 0.
- R10: reg_we_o is 1 for ADD, SUB, OR, MOV, FMA, ADDI, ORI, INC and LW. mem_rd_o is 1 only for LW and mem_wr_o only for SW.
- R11: rs2_idx_o is instr[16:12] for ADD, SUB, OR and FMA, and instr[21:17] for SW and BEQ. It is 0 otherwise.
- R12: uop_o is NOP=0, ADD=1, SUB=2, OR=3, ADDI=4, ORI=5, LOAD=6, STORE=7, BRANCH=8, JUMP=9 or FMA=10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| op_disable_i | input | 32 | Per-opcode trap mask, bit n for opcode n |
| alu_src_imm_o | output | 1 | ALU operand B source, 1 = immediate |
| pc_sel_o | output | 2 | Next-PC source: 00 PC+4, 01 branch, 10 jump |
| alu_op_o | output | 2 | ALU operation class |
| uop_o | output | 4 | Unified micro-operation code |
| rd_idx_o | output | 5 | Merged destination register index |
| rs2_idx_o | output | 5 | Second source register index |
| imm_o | output | 32 | Extended immediate |
| reg_we_o | output | 1 | Register write enable |
| mem_rd_o | output | 1 | Memory read enable |
| mem_wr_o | output | 1 | Memory write enable |
| illegal_o | output | 1 | Illegal or disabled instruction |

## Verification
A sweep over all 32 opcodes with a fixed operand pattern and a clear mask separates the defined set from the undefined encodings, field by field. Paired words that differ only in opcode show whether MOV matches ADD and INC matches ADDI. Single-bit disable masks, aimed once at the decoded opcode and once elsewhere, show the trap is tied to the right bit. Seeded random words with sparse random masks exercise field extraction and sign extension across arbitrary register and immediate bits.

// File: rtl/dec_pkg.sv
// Package dec_pkg
// Holds the opcode encodings, micro-operation codes and the decoded
// opcode-class record shared by the decoder modules.
// Assumes a 5-bit opcode held at the top of the instruction word.
package dec_pkg;

    localparam int OP_W   = 5;
    localparam int NUM_OP = 1 << OP_W;

    localparam logic [OP_W-1:0] OPC_ADD  = 5'd0;
    localparam logic [OP_W-1:0] OPC_SUB  = 5'd1;
    localparam logic [OP_W-1:0] OPC_OR   = 5'd2;
    localparam logic [OP_W-1:0] OPC_MOV  = 5'd3;
    localparam logic [OP_W-1:0] OPC_ADDI = 5'd4;
    localparam logic [OP_W-1:0] OPC_ORI  = 5'd5;
    localparam logic [OP_W-1:0] OPC_INC  = 5'd6;
    localparam logic [OP_W-1:0] OPC_LW   = 5'd7;
    localparam logic [OP_W-1:0] OPC_SW   = 5'd8;
    localparam logic [OP_W-1:0] OPC_BEQ  = 5'd9;
    localparam logic [OP_W-1:0] OPC_J    = 5'd10;
    localparam logic [OP_W-1:0] OPC_FMA  = 5'd11;
    localparam int              NUM_DEF  = 12;

    typedef enum logic [3:0] {
        UOP_NOP    = 4'd0,
        UOP_ADD    = 4'd1,
        UOP_SUB    = 4'd2,
        UOP_OR     = 4'd3,
        UOP_ADDI   = 4'd4,
        UOP_ORI    = 4'd5,
        UOP_LOAD   = 4'd6,
        UOP_STORE  = 4'd7,
        UOP_BRANCH = 4'd8,
        UOP_JUMP   = 4'd9,
        UOP_FMA    = 4'd10
    } uop_e;

    // One flag per defined instruction, already gated by legality.
    typedef struct packed {
        logic add;
        logic sub;
        logic orr;
        logic mov;
        logic addi;
        logic ori;
        logic inc;
        logic lw;
        logic sw;
        logic beq;
        logic jmp;
        logic fma;
    } op_hits_t;

    // Set of opcodes that carry a defined instruction.
    function automatic logic [NUM_OP-1:0] defined_set();
        logic [NUM_OP-1:0] s;
        s = '0;
        for (int i = 0; i < NUM_DEF; i++) s[i] = 1'b1;
        return s;
    endfunction

endpackage

// File: rtl/opc_class.sv
// Module opc_class
// Expands the opcode one-hot and combines it with the defined set and the
// run-time disable mask; emits per-instruction hit flags and illegal.
// Assumes opcode encodings are contiguous from zero (see dec_pkg).
module opc_class
    import dec_pkg::*;
(
    input  logic [OP_W-1:0]   op_i,
    input  logic [NUM_OP-1:0] dis_i,
    output op_hits_t          hits_o,
    output logic              illegal_o
);

    localparam logic [NUM_OP-1:0] DEF_SET = defined_set();

    logic [NUM_OP-1:0] onehot;
    logic [NUM_OP-1:0] live;

    // One match term per encoding, generated from the opcode width.
    for (genvar g = 0; g < NUM_OP; g++) begin : g_match
        assign onehot[g] = (op_i == OP_W'(g));
    end

    assign live      = onehot & DEF_SET & ~dis_i;
    assign illegal_o = ~|live;

    // Name the live match terms for the control logic.
    always_comb begin
        hits_o.add  = live[OPC_ADD];
        hits_o.sub  = live[OPC_SUB];
        hits_o.orr  = live[OPC_OR];
        hits_o.mov  = live[OPC_MOV];
        hits_o.addi = live[OPC_ADDI];
        hits_o.ori  = live[OPC_ORI];
        hits_o.inc  = live[OPC_INC];
        hits_o.lw   = live[OPC_LW];
        hits_o.sw   = live[OPC_SW];
        hits_o.beq  = live[OPC_BEQ];
        hits_o.jmp  = live[OPC_J];
        hits_o.fma  = live[OPC_FMA];
    end

endmodule

// File: rtl/ctrl_gen.sv
// Module ctrl_gen
// Sum-of-products control plane: builds shared class terms once and fans
// them to every control output; folds MOV/INC onto ADD/ADDI.
// Assumes hit flags are already zero for illegal or disabled opcodes.
module ctrl_gen
    import dec_pkg::*;
(
    input  op_hits_t    h_i,
    output logic        is_rtype_o,
    output logic        is_iwr_o,
    output logic        alu_src_imm_o,
    output logic [1:0]  pc_sel_o,
    output logic [1:0]  alu_op_o,
    output uop_e        uop_o,
    output logic        reg_we_o,
    output logic        mem_rd_o,
    output logic        mem_wr_o
);

    logic is_rtype;
    logic is_iwr;

    // Shared product terms, reused by several outputs.
    assign is_rtype = h_i.add | h_i.sub | h_i.orr | h_i.mov | h_i.fma;
    assign is_iwr   = h_i.addi | h_i.ori | h_i.inc | h_i.lw;

    assign is_rtype_o    = is_rtype;
    assign is_iwr_o      = is_iwr;
    assign alu_src_imm_o = is_iwr | h_i.sw;
    assign pc_sel_o      = {h_i.jmp, h_i.beq};
    assign alu_op_o      = {is_rtype | h_i.ori, h_i.ori | h_i.beq};
    assign reg_we_o      = is_rtype | is_iwr;
    assign mem_rd_o      = h_i.lw;
    assign mem_wr_o      = h_i.sw;

    // Micro-op selection; synonyms share their base operation.
    always_comb begin
        uop_o = UOP_NOP;
        if (h_i.add | h_i.mov)  uop_o = UOP_ADD;
        if (h_i.sub)            uop_o = UOP_SUB;
        if (h_i.orr)            uop_o = UOP_OR;
        if (h_i.addi | h_i.inc) uop_o = UOP_ADDI;
        if (h_i.ori)            uop_o = UOP_ORI;
        if (h_i.lw)             uop_o = UOP_LOAD;
        if (h_i.sw)             uop_o = UOP_STORE;
        if (h_i.beq)            uop_o = UOP_BRANCH;
        if (h_i.jmp)            uop_o = UOP_JUMP;
        if (h_i.fma)            uop_o = UOP_FMA;
    end

endmodule

// File: rtl/field_merge.sv
// Module field_merge
// Picks register indices and the immediate out of the operand bits so the
// datapath sees one destination bus and no format multiplexers.
// Assumes R-form rd/rs1/rs2 and I-form rs1/rd/imm layouts below the opcode.
module field_merge #(
    parameter int BODY_W = 27,
    parameter int REG_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic [BODY_W-1:0] body_i,
    input  logic              rtype_i,
    input  logic              iwr_i,
    input  logic              mov_i,
    input  logic              inc_i,
    input  logic              imm_use_i,
    input  logic              irs2_i,
    output logic [REG_W-1:0]  rd_o,
    output logic [REG_W-1:0]  rs2_o,
    output logic [DATA_W-1:0] imm_o
);

    localparam int R_RD_LSB  = BODY_W - REG_W;
    localparam int I_RD_LSB  = R_RD_LSB - REG_W;
    localparam int R_RS2_LSB = I_RD_LSB - REG_W;
    localparam int IMM_W     = I_RD_LSB;

    logic [REG_W-1:0] r_rd, i_rd, r_rs2;
    logic [IMM_W-1:0] imm_raw;

    assign r_rd    = body_i[R_RD_LSB  +: REG_W];
    assign i_rd    = body_i[I_RD_LSB  +: REG_W];
    assign r_rs2   = body_i[R_RS2_LSB +: REG_W];
    assign imm_raw = body_i[IMM_W-1:0];

    // Merged destination index; zero when nothing is written.
    always_comb begin
        rd_o = '0;
        if (rtype_i)    rd_o = r_rd;
        else if (iwr_i) rd_o = i_rd;
    end

    // Second source index; MOV reads the zero register.
    always_comb begin
        rs2_o = '0;
        if (rtype_i && !mov_i) rs2_o = r_rs2;
        else if (irs2_i)       rs2_o = i_rd;
    end

    // Immediate: sign-extended field, or the fixed increment for INC.
    always_comb begin
        imm_o = '0;
        if (inc_i)          imm_o = DATA_W'(1);
        else if (imm_use_i) imm_o = {{(DATA_W-IMM_W){imm_raw[IMM_W-1]}}, imm_raw};
    end

endmodule

// File: rtl/op_decoder.sv
// Module op_decoder
// Top of the hardwired instruction decoder: opcode classing, control
// generation and operand-field merging, all combinational.
// Assumes instruction width 32 and a 5-bit opcode in the top bits.
module op_decoder
    import dec_pkg::*;
#(
    parameter int INSTR_W = 32,
    parameter int REG_W   = 5
) (
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [NUM_OP-1:0]  op_disable_i,
    output logic               alu_src_imm_o,
    output logic [1:0]         pc_sel_o,
    output logic [1:0]         alu_op_o,
    output logic [3:0]         uop_o,
    output logic [REG_W-1:0]   rd_idx_o,
    output logic [REG_W-1:0]   rs2_idx_o,
    output logic [INSTR_W-1:0] imm_o,
    output logic               reg_we_o,
    output logic               mem_rd_o,
    output logic               mem_wr_o,
    output logic               illegal_o
);

    localparam int BODY_W = INSTR_W - OP_W;

    op_hits_t hits;
    logic     rtype, iwr;
    uop_e     uop;

    opc_class u_class (
        .op_i      (instr_i[INSTR_W-1 -: OP_W]),
        .dis_i     (op_disable_i),
        .hits_o    (hits),
        .illegal_o (illegal_o)
    );

    ctrl_gen u_ctrl (
        .h_i           (hits),
        .is_rtype_o    (rtype),
        .is_iwr_o      (iwr),
        .alu_src_imm_o (alu_src_imm_o),
        .pc_sel_o      (pc_sel_o),
        .alu_op_o      (alu_op_o),
        .uop_o         (uop),
        .reg_we_o      (reg_we_o),
        .mem_rd_o      (mem_rd_o),
        .mem_wr_o      (mem_wr_o)
    );

    assign uop_o = uop;

    field_merge #(
        .BODY_W (BODY_W),
        .REG_W  (REG_W),
        .DATA_W (INSTR_W)
    ) u_fields (
        .body_i    (instr_i[BODY_W-1:0]),
        .rtype_i   (rtype),
        .iwr_i     (iwr),
        .mov_i     (hits.mov),
        .inc_i     (hits.inc),
        .imm_use_i (hits.addi | hits.ori | hits.lw | hits.sw | hits.beq),
        .irs2_i    (hits.sw | hits.beq),
        .rd_o      (rd_idx_o),
        .rs2_o     (rs2_idx_o),
        .imm_o     (imm_o)
    );

    // Cross-module consistency checks on the settled outputs.
    always_comb begin
        // R1
        illegal_quiet_chk: assert (!illegal_o || (!reg_we_o && !mem_rd_o && !mem_wr_o && pc_sel_o == 2'b00 && uop_o == 4'd0));
        // R4
        pc_code_chk: assert (pc_sel_o != 2'b11);
        // R6
        rd_idle_chk: assert (reg_we_o || rd_idx_o == '0);
        // R10
        mem_excl_chk: assert (!(mem_rd_o && mem_wr_o));
        // R3
        store_imm_chk: assert (!mem_wr_o || alu_src_imm_o);
        // R7
        mov_zero_chk: assert (illegal_o || instr_i[INSTR_W-1 -: OP_W] != OPC_MOV || (rs2_idx_o == '0 && uop_o == 4'd1));
    end

endmodule

// File: tb/op_decoder_tb.sv
module op_decoder_tb;

    logic        clk = 1'b0;
    logic [31:0] instr, dmask;
    logic        src_imm, we, mrd, mwr, ill;
    logic [1:0]  pcs, aop;
    logic [3:0]  uop;
    logic [4:0]  rd, rs2;
    logic [31:0] imm;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done  = 1'b0;

    always #2 clk = ~clk;

    op_decoder u_dut (
        .instr_i(instr), .op_disable_i(dmask), .alu_src_imm_o(src_imm),
        .pc_sel_o(pcs), .alu_op_o(aop), .uop_o(uop), .rd_idx_o(rd),
        .rs2_idx_o(rs2), .imm_o(imm), .reg_we_o(we), .mem_rd_o(mrd),
        .mem_wr_o(mwr), .illegal_o(ill)
    );

    typedef struct packed {
        logic       src; logic [1:0] pc; logic [1:0] aop; logic [3:0] uop;
        logic [4:0] rd;  logic [4:0] rs2; logic [31:0] imm;
        logic       we;  logic mr; logic mw; logic ill;
    } exp_t;

    // Expected outputs from the requirement text.
    function automatic exp_t model(input logic [31:0] w, input logic [31:0] m);
        exp_t e;
        int   op = int'(w[31:27]);
        logic [31:0] sx = {{15{w[16]}}, w[16:0]};
        e = '0;
        if (op > 11 || m[op]) begin e.ill = 1'b1; return e; end
        case (op)
            0, 1, 2, 11: begin e.aop = 2'b10; e.we = 1'b1; e.rd = w[26:22]; e.rs2 = w[16:12];
                         e.uop = (op == 11) ? 4'd10 : 4'(op + 1); end
            3:  begin e.aop = 2'b10; e.we = 1'b1; e.rd = w[26:22]; e.uop = 4'd1; end
            4:  begin e.src = 1; e.we = 1; e.rd = w[21:17]; e.imm = sx; e.uop = 4'd4; end
            5:  begin e.src = 1; e.we = 1; e.rd = w[21:17]; e.imm = sx; e.uop = 4'd5; e.aop = 2'b11; end
            6:  begin e.src = 1; e.we = 1; e.rd = w[21:17]; e.imm = 32'd1; e.uop = 4'd4; end
            7:  begin e.src = 1; e.we = 1; e.rd = w[21:17]; e.imm = sx; e.uop = 4'd6; e.mr = 1; end
            8:  begin e.src = 1; e.rs2 = w[21:17]; e.imm = sx; e.uop = 4'd7; e.mw = 1; end
            9:  begin e.pc = 2'b01; e.aop = 2'b01; e.rs2 = w[21:17]; e.imm = sx; e.uop = 4'd8; end
            default: begin e.pc = 2'b10; e.uop = 4'd9; end
        endcase
        return e;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] ex);
        n_chk++;
        if (act !== ex) begin
            n_err++;
            $display("FAIL %s instr=%h mask=%h act=%h exp=%h", tag, instr, dmask, act, ex);
        end
    endtask

    // Apply one vector, wait for the settled outputs, compare every field.
    task automatic apply(input logic [31:0] w, input logic [31:0] m);
        exp_t e;
        @(posedge clk); instr = w; dmask = m;
        @(negedge clk);
        e = model(w, m);
        chk("R1/R2 illegal", 32'(ill), 32'(e.ill));
        chk("R3 alu_src", 32'(src_imm), 32'(e.src));
        chk("R4 pc_sel", 32'(pcs), 32'(e.pc));
        chk("R5 alu_op", 32'(aop), 32'(e.aop));
        chk("R6 rd_idx", 32'(rd), 32'(e.rd));
        chk("R11 rs2_idx", 32'(rs2), 32'(e.rs2));
        chk("R9 imm", imm, e.imm);
        chk("R10 reg_we", 32'(we), 32'(e.we));
        chk("R10 mem", {30'd0, mrd, mwr}, {30'd0, e.mr, e.mw});
        chk("R12 uop", 32'(uop), 32'(e.uop));
    endtask

    initial begin
        logic [31:0] base, wa, wb;
        logic [3:0]  u_add;
        logic [1:0]  a_add;
        void'($urandom(32'd20240611));
        instr = '0; dmask = '0;
        // Reset-like start: ADD with all-zero operands.
        apply(32'h0, 32'h0);
        // R1: sweep every opcode with a fixed operand pattern.
        base = 32'h07FF_F5A5;
        for (int o = 0; o < 32; o++) apply({5'(o), base[26:0]}, 32'h0);
        // R7: MOV versus ADD with the same operand bits.
        wa = {5'd0, 27'h1ABCDEF}; wb = {5'd3, 27'h1ABCDEF};
        apply(wa, 0); u_add = uop; a_add = aop;
        apply(wb, 0);
        chk("R7 mov_uop_eq_add", 32'(uop), 32'(u_add));
        chk("R7 mov_aop_eq_add", 32'(aop), 32'(a_add));
        chk("R7 mov_rs2_zero", 32'(rs2), 32'd0);
        // R8: INC ignores its immediate field.
        apply({5'd6, 5'd3, 5'd9, 17'h1FFFF}, 0);
        chk("R8 inc_imm", imm, 32'd1);
        chk("R8 inc_uop", 32'(uop), 32'd4);
        // R9: negative and positive immediates.
        apply({5'd4, 5'd1, 5'd2, 17'h10000}, 0);
        apply({5'd5, 5'd1, 5'd2, 17'h0FFFF}, 0);
        // R2: disable FMA, then mask other bits only.
        apply({5'd11, 27'h0123456}, 32'h0000_0800);
        chk("R2 fma_trapped", 32'(ill), 32'd1);
        apply({5'd11, 27'h0123456}, 32'hFFFF_F7FF);
        chk("R2 fma_other_mask", 32'(we), 32'd1);
        apply({5'd20, 27'h0}, 32'h0010_0000);
        // Seeded random words with sparse masks.
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] w, m;
            w = $urandom;
            m = ($urandom % 4 == 0) ? (32'd1 << ($urandom % 32)) : 32'd0;
            apply(w, m);
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog act=timeout exp=done");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule